// File: doc/BRIEF.md
# Smartcard-Mode UART Receiver

This block is the receive half of a UART used to talk to a smartcard-style serial line. It oversamples the incoming line with an enable strobe that runs at sixteen times the bit rate. It finds each start bit and samples every later bit at its centre. It assembles a character of 5 to 8 data bits, sent least significant bit first. It then checks the optional parity bit and the first stop bit, and it recognises a line break.

Completed characters go into a four-entry receive queue. The host pops entries from the queue and always sees the oldest entry on a show-ahead data output. Status outputs report:
- whether the queue is empty or full;
- a data-ready condition tied to a programmable fill threshold;
- an idle-timeout flag;
- three sticky error flags that the host clears by writing 1.

A single interrupt line combines the sources, each gated by its own enable. The character-length and parity inputs use the same encodings as the companion transmitter, so one configuration word can drive both.

Top module: `card_uart_rx`

## Requirements
- R1: Data bits are taken least significant first and sampled near the middle of each bit. `charLen` selects the data width: 0 = 8 bits, 1 = 7, 2 = 6, 3 = 5. Unused upper bits of `rdData` read as zero, and `rdData` always shows the oldest stored character.
- R2: With `parityOff` = 1 no parity bit is expected. Otherwise one parity bit follows the data; it gives even parity when `parityOdd` = 0 and odd parity when `parityOdd` = 1. A mismatch sets `parityErr`, and the character is still stored.
- R3: The queue holds 4 characters in arrival order. `rxFull` is high exactly when 4 are stored. A character that completes while the queue is full is discarded.
- R4: `rxEmpty` is high after reset and after the host pops the last stored character. It goes low as soon as any character is received.
- R5: `rdaStatus` is high while the stored count is at least the threshold. The threshold is set by `trigLevel`: 0 gives 1 character, 1 gives 2, and 2 or 3 give 3.
- R6: A first stop bit that samples low sets `frameErr`.
- R7: A character whose start, data, parity and stop samples are all low sets `breakErr`, and it also sets `frameErr`. The receiver then waits for the line to return high before it looks for a new start bit.
- R8: `errClr` bit 0 clears `parityErr`, bit 1 clears `frameErr` and bit 2 clears `breakErr`, each independently. A 0 in any bit leaves that flag unchanged.
- R9: With `toCount` nonzero and data in the queue, `toFlag` sets after the line has stayed idle for `toCount` bit times. A received character or a host pop restarts the count. `toCount` = 0 disables the timeout. `toClr` clears the flag.
- R10: `irq` is the OR of three terms: `rdaStatus` AND `ieRda`, `toFlag` AND `ieTo`, and the OR of the three error flags AND `ieErr`.
- R11: A low pulse on the line that ends before the middle of the start bit does not start a character.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| sampleTick | input | 1 | Oversampling enable, 16 per bit |
| rxLine | input | 1 | Serial receive line, idle high |
| charLen | input | 2 | Data width code |
| parityOff | input | 1 | 1 = no parity bit |
| parityOdd | input | 1 | 1 = odd parity, 0 = even |
| trigLevel | input | 2 | Data-ready threshold code |
| toCount | input | 8 | Idle timeout in bit times, 0 = off |
| rdEn | input | 1 | Pop the oldest character |
| errClr | input | 3 | Write-1 clear: parity, frame, break |
| toClr | input | 1 | Write-1 clear of timeout flag |
| ieRda | input | 1 | Data-ready interrupt enable |
| ieTo | input | 1 | Timeout interrupt enable |
| ieErr | input | 1 | Error interrupt enable |
| rdData | output | 8 | Oldest stored character |
| rxEmpty | output | 1 | Queue empty |
| rxFull | output | 1 | Queue full |
| rdaStatus | output | 1 | Fill at or above threshold |
| toFlag | output | 1 | Idle timeout flag |
| parityErr | output | 1 | Parity error flag |
| frameErr | output | 1 | Frame error flag |
| breakErr | output | 1 | Break flag |
| irq | output | 1 | Combined interrupt |

## Verification
Random rounds vary the character width, the parity mode, the threshold code and the number of queued characters from one to four. These rounds separate bit-order and masking faults from queue-order faults, and they show each threshold boundary. Directed frames then check the error paths:
- a wrong parity bit, a low stop bit on nonzero data, and an all-low break, which tell the three error flags apart;
- a fifth character, which shows that an overflow drops the character instead of overwriting an entry;
- a short glitch, which tests the start-bit check;
- idle waits on either side of the timeout window, and with the count at zero, which pin down when the timeout fires.

// File: rtl/card_uart_rx_pkg.sv
package card_uart_rx_pkg;

  typedef enum logic [2:0] {
    S_IDLE, S_START, S_DATA, S_PAR, S_STOP, S_HOLD
  } rxState_t;

  // Strobes from the bit-level control to the storage datapath.
  typedef struct packed {
    logic       push;
    logic [7:0] data;
    logic       parErr;
    logic       frmErr;
    logic       brkErr;
    logic       bitTick;
    logic       busy;
  } rxStrobe_t;

endpackage

// File: rtl/card_uart_rx_ctrl.sv
module card_uart_rx_ctrl
  import card_uart_rx_pkg::*;
#(
  parameter int OSR = 16
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       sampleTick,
  input  logic       rxLine,
  input  logic [1:0] charLen,
  input  logic       parityOff,
  input  logic       parityOdd,
  output rxStrobe_t  strobe
);
  localparam int CW = $clog2(OSR);
  localparam logic [CW-1:0] MID  = CW'(OSR/2 - 1);
  localparam logic [CW-1:0] LAST = CW'(OSR - 1);

  rxState_t      state;
  logic [1:0]    syncQ;
  logic          rxS;
  logic [CW-1:0] tickCnt;
  logic [CW-1:0] prescale;
  logic [2:0]    bitIdx;
  logic [7:0]    shiftReg;
  logic          parAcc;
  logic          allZero;
  logic          pushQ, parQ, frmQ, brkQ;
  logic [7:0]    dataQ;
  logic [2:0]    lastIdx;
  logic          atSample;

  assign rxS      = syncQ[1];
  assign lastIdx  = 3'd7 - {1'b0, charLen};
  assign atSample = sampleTick && (tickCnt == LAST);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      syncQ    <= 2'b11;
      prescale <= '0;
    end else begin
      syncQ <= {syncQ[0], rxLine};
      if (sampleTick) prescale <= prescale + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state    <= S_IDLE;
      tickCnt  <= '0;
      bitIdx   <= '0;
      shiftReg <= '0;
      parAcc   <= 1'b0;
      allZero  <= 1'b0;
      pushQ    <= 1'b0;
      parQ     <= 1'b0;
      frmQ     <= 1'b0;
      brkQ     <= 1'b0;
      dataQ    <= '0;
    end else begin
      pushQ <= 1'b0;
      unique case (state)
        S_IDLE: begin
          if (sampleTick && !rxS) begin
            state   <= S_START;
            tickCnt <= '0;
          end
        end
        S_START: begin
          if (sampleTick) begin
            if (tickCnt == MID) begin
              tickCnt <= '0;
              if (!rxS) begin
                state    <= S_DATA;
                bitIdx   <= '0;
                shiftReg <= '0;
                parAcc   <= 1'b0;
                allZero  <= 1'b1;
              end else begin
                state <= S_IDLE;
              end
            end else begin
              tickCnt <= tickCnt + 1'b1;
            end
          end
        end
        S_DATA: begin
          if (atSample) begin
            tickCnt          <= '0;
            shiftReg[bitIdx] <= rxS;
            parAcc           <= parAcc ^ rxS;
            allZero          <= allZero & ~rxS;
            if (bitIdx == lastIdx) state <= parityOff ? S_STOP : S_PAR;
            else                   bitIdx <= bitIdx + 1'b1;
          end else if (sampleTick) begin
            tickCnt <= tickCnt + 1'b1;
          end
        end
        S_PAR: begin
          if (atSample) begin
            tickCnt <= '0;
            parAcc  <= parAcc ^ rxS;
            allZero <= allZero & ~rxS;
            state   <= S_STOP;
          end else if (sampleTick) begin
            tickCnt <= tickCnt + 1'b1;
          end
        end
        S_STOP: begin
          if (atSample) begin
            tickCnt <= '0;
            pushQ   <= 1'b1;
            dataQ   <= shiftReg;
            parQ    <= !parityOff && (parAcc ^ parityOdd);
            frmQ    <= !rxS;
            brkQ    <= !rxS && allZero;
            state   <= rxS ? S_IDLE : S_HOLD;
          end else if (sampleTick) begin
            tickCnt <= tickCnt + 1'b1;
          end
        end
        S_HOLD: begin
          if (rxS) state <= S_IDLE;
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  always_comb begin
    strobe.push    = pushQ;
    strobe.data    = dataQ;
    strobe.parErr  = parQ;
    strobe.frmErr  = frmQ;
    strobe.brkErr  = brkQ;
    strobe.bitTick = sampleTick && (prescale == LAST);
    strobe.busy    = (state != S_IDLE);
  end

  // R1: a character is only handed over after the stop-bit sample
  assert_push_after_stop_R1: assert property (@(posedge clk) disable iff (!rstN)
    pushQ |-> $past(state == S_STOP));

  // R7: a break always carries a frame error with it
  assert_break_has_frame_R7: assert property (@(posedge clk) disable iff (!rstN)
    brkQ |-> frmQ);

  // R7: after a low stop sample the receiver waits for the line to go high
  assert_hold_until_high_R7: assert property (@(posedge clk) disable iff (!rstN)
    (state == S_HOLD && !rxS) |=> state == S_HOLD);

endmodule

// File: rtl/card_uart_rx_data.sv
module card_uart_rx_data
  import card_uart_rx_pkg::*;
#(
  parameter int DEPTH = 4,
  parameter int TO_W  = 8
) (
  input  logic            clk,
  input  logic            rstN,
  input  rxStrobe_t       strobe,
  input  logic [1:0]      trigLevel,
  input  logic [TO_W-1:0] toCount,
  input  logic            rdEn,
  input  logic [2:0]      errClr,
  input  logic            toClr,
  output logic [7:0]      rdData,
  output logic            rxEmpty,
  output logic            rxFull,
  output logic            rdaStatus,
  output logic            toFlag,
  output logic            parityErr,
  output logic            frameErr,
  output logic            breakErr
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int NW = $clog2(DEPTH + 1);
  localparam logic [NW-1:0] FULLN = NW'(DEPTH);

  logic [7:0]      mem [DEPTH];
  logic [PW-1:0]   wrPtr, rdPtr;
  logic [NW-1:0]   count;
  logic [NW-1:0]   thr;
  logic [TO_W-1:0] toCnt;
  logic            doPush, doPop;

  assign doPush    = strobe.push && (count != FULLN);
  assign doPop     = rdEn && (count != '0);
  assign rxEmpty   = (count == '0);
  assign rxFull    = (count == FULLN);
  assign rdData    = mem[rdPtr];
  assign rdaStatus = (count >= thr);

  always_comb begin
    unique case (trigLevel)
      2'd0:    thr = NW'(1);
      2'd1:    thr = NW'(2);
      default: thr = NW'(3);
    endcase
  end

  function automatic logic [PW-1:0] nextPtr(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrPtr <= '0;
      rdPtr <= '0;
      count <= '0;
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else begin
      if (doPush) begin
        mem[wrPtr] <= strobe.data;
        wrPtr      <= nextPtr(wrPtr);
      end
      if (doPop) rdPtr <= nextPtr(rdPtr);
      if (doPush && !doPop)      count <= count + 1'b1;
      else if (doPop && !doPush) count <= count - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      parityErr <= 1'b0;
      frameErr  <= 1'b0;
      breakErr  <= 1'b0;
    end else begin
      if (strobe.push && strobe.parErr) parityErr <= 1'b1;
      else if (errClr[0])               parityErr <= 1'b0;
      if (strobe.push && strobe.frmErr) frameErr <= 1'b1;
      else if (errClr[1])               frameErr <= 1'b0;
      if (strobe.push && strobe.brkErr) breakErr <= 1'b1;
      else if (errClr[2])               breakErr <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      toCnt  <= '0;
      toFlag <= 1'b0;
    end else begin
      if (toCount == '0 || count == '0 || strobe.push || doPop || strobe.busy) begin
        toCnt <= '0;
      end else if (strobe.bitTick && toCnt != toCount) begin
        toCnt <= toCnt + 1'b1;
      end
      if (toCount != '0 && count != '0 && !strobe.push && !doPop && !strobe.busy &&
          strobe.bitTick && toCnt != toCount && (toCnt + 1'b1) == toCount)
        toFlag <= 1'b1;
      else if (toClr)
        toFlag <= 1'b0;
    end
  end

  // R3: occupancy never exceeds the queue depth
  assert_no_overflow_R3: assert property (@(posedge clk) disable iff (!rstN)
    count <= FULLN);

  // R3: a character arriving while full leaves the queue full and unchanged
  assert_drop_when_full_R3: assert property (@(posedge clk) disable iff (!rstN)
    (rxFull && strobe.push && !rdEn) |=> (rxFull && $stable(wrPtr)));

  // R4: empty and full are never reported together
  assert_empty_full_excl_R4: assert property (@(posedge clk) disable iff (!rstN)
    !(rxEmpty && rxFull));

  // R8: a write-1 on the parity bit clears it unless a new error arrives
  assert_w1c_parity_R8: assert property (@(posedge clk) disable iff (!rstN)
    (errClr[0] && !(strobe.push && strobe.parErr)) |=> !parityErr);

  // R9: the timeout flag only rises while data is waiting
  assert_timeout_needs_data_R9: assert property (@(posedge clk) disable iff (!rstN)
    $rose(toFlag) |-> $past(count != '0));

endmodule

// File: rtl/card_uart_rx.sv
module card_uart_rx
  import card_uart_rx_pkg::*;
#(
  parameter int OSR   = 16,
  parameter int DEPTH = 4,
  parameter int TO_W  = 8
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            sampleTick,
  input  logic            rxLine,
  input  logic [1:0]      charLen,
  input  logic            parityOff,
  input  logic            parityOdd,
  input  logic [1:0]      trigLevel,
  input  logic [TO_W-1:0] toCount,
  input  logic            rdEn,
  input  logic [2:0]      errClr,
  input  logic            toClr,
  input  logic            ieRda,
  input  logic            ieTo,
  input  logic            ieErr,
  output logic [7:0]      rdData,
  output logic            rxEmpty,
  output logic            rxFull,
  output logic            rdaStatus,
  output logic            toFlag,
  output logic            parityErr,
  output logic            frameErr,
  output logic            breakErr,
  output logic            irq
);
  rxStrobe_t strobe;

  card_uart_rx_ctrl #(.OSR(OSR)) i_ctrl (
    .clk(clk), .rstN(rstN), .sampleTick(sampleTick), .rxLine(rxLine),
    .charLen(charLen), .parityOff(parityOff), .parityOdd(parityOdd),
    .strobe(strobe)
  );

  card_uart_rx_data #(.DEPTH(DEPTH), .TO_W(TO_W)) i_data (
    .clk(clk), .rstN(rstN), .strobe(strobe), .trigLevel(trigLevel),
    .toCount(toCount), .rdEn(rdEn), .errClr(errClr), .toClr(toClr),
    .rdData(rdData), .rxEmpty(rxEmpty), .rxFull(rxFull), .rdaStatus(rdaStatus),
    .toFlag(toFlag), .parityErr(parityErr), .frameErr(frameErr), .breakErr(breakErr)
  );

  assign irq = (rdaStatus & ieRda) | (toFlag & ieTo) |
               ((parityErr | frameErr | breakErr) & ieErr);

  // R10: the line never rises without an enabled source behind it
  assert_irq_source_R10: assert property (@(posedge clk) disable iff (!rstN)
    irq |-> ((ieRda && rdaStatus) || (ieTo && toFlag) ||
             (ieErr && (parityErr || frameErr || breakErr))));

endmodule

// File: tb/test_card_uart_rx.sv
module test_card_uart_rx;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       sampleTick = 1'b1;
  logic       rxLine = 1'b1;
  logic [1:0] charLen = 2'd0;
  logic       parityOff = 1'b1;
  logic       parityOdd = 1'b0;
  logic [1:0] trigLevel = 2'd0;
  logic [7:0] toCount = 8'd0;
  logic       rdEn = 1'b0;
  logic [2:0] errClr = 3'd0;
  logic       toClr = 1'b0;
  logic       ieRda = 1'b0, ieTo = 1'b0, ieErr = 1'b0;
  logic [7:0] rdData;
  logic       rxEmpty, rxFull, rdaStatus, toFlag, parityErr, frameErr, breakErr, irq;

  int vectors = 0;
  int misses  = 0;
  bit done    = 0;

  always #5 clk = ~clk;

  card_uart_rx i_card_uart_rx (
    .clk(clk), .rstN(rstN), .sampleTick(sampleTick), .rxLine(rxLine),
    .charLen(charLen), .parityOff(parityOff), .parityOdd(parityOdd),
    .trigLevel(trigLevel), .toCount(toCount), .rdEn(rdEn), .errClr(errClr),
    .toClr(toClr), .ieRda(ieRda), .ieTo(ieTo), .ieErr(ieErr),
    .rdData(rdData), .rxEmpty(rxEmpty), .rxFull(rxFull), .rdaStatus(rdaStatus),
    .toFlag(toFlag), .parityErr(parityErr), .frameErr(frameErr),
    .breakErr(breakErr), .irq(irq)
  );

  function automatic int nBits(input logic [1:0] code);
    return 8 - int'(code);
  endfunction

  function automatic logic [7:0] maskData(input logic [7:0] d, input logic [1:0] code);
    return d & ((8'd1 << nBits(code)) - 8'd1);
  endfunction

  function automatic int thrOf(input logic [1:0] code);
    return (code == 2'd0) ? 1 : (code == 2'd1) ? 2 : 3;
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      misses++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic bitTime(input logic v);
    rxLine = v;
    repeat (16) @(negedge clk);
  endtask

  // Drives one character with the current line settings.
  task automatic sendFrame(input logic [7:0] d, input logic badPar, input logic stopLow);
    logic [7:0] m;
    m = maskData(d, charLen);
    bitTime(1'b0);
    for (int i = 0; i < nBits(charLen); i++) bitTime(m[i]);
    if (!parityOff) bitTime((^m) ^ parityOdd ^ badPar);
    bitTime(!stopLow);
    if (stopLow) bitTime(1'b1);
    rxLine = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  task automatic popCheck(input string tag, input logic [7:0] exp);
    check(tag, rdData, exp);
    rdEn = 1'b1;
    @(negedge clk);
    rdEn = 1'b0;
  endtask

  task automatic drain();
    while (!rxEmpty) begin
      rdEn = 1'b1;
      @(negedge clk);
      rdEn = 1'b0;
    end
  endtask

  task automatic clearAll();
    errClr = 3'b111;
    toClr  = 1'b1;
    @(negedge clk);
    errClr = 3'b000;
    toClr  = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      misses++;
      vectors++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
      $finish;
    end
  end

  initial begin
    logic [7:0] q [4];
    int n;
    void'($urandom(32'd20240517));
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R4: reset state
    check("R4 reset empty", rxEmpty, 1);
    check("R3 reset full", rxFull, 0);
    check("R10 reset irq", irq, 0);
    check("R8 reset flags", {parityErr, frameErr, breakErr, toFlag}, 0);

    // R1 R2 R3 R4 R5: random rounds
    for (int r = 0; r < 10; r++) begin
      charLen   = 2'($urandom_range(0, 3));
      parityOff = 1'($urandom_range(0, 1));
      parityOdd = 1'($urandom_range(0, 1));
      trigLevel = 2'($urandom_range(0, 3));
      n = $urandom_range(1, 4);
      for (int k = 0; k < n; k++) begin
        q[k] = 8'($urandom);
        sendFrame(q[k], 1'b0, 1'b0);
        check("R4 empty low after receive", rxEmpty, 0);
        check("R5 data-ready threshold", rdaStatus, (k + 1 >= thrOf(trigLevel)) ? 1 : 0);
        check("R3 full flag", rxFull, (k == 3) ? 1 : 0);
      end
      check("R2 no parity error on good frames", parityErr, 0);
      for (int k = 0; k < n; k++) popCheck("R1 data order and width", maskData(q[k], charLen));
      check("R4 empty after last read", rxEmpty, 1);
    end

    // R3: fifth character is dropped
    charLen = 2'd0; parityOff = 1'b1; trigLevel = 2'd0;
    for (int k = 0; k < 5; k++) begin
      q[k % 4] = 8'h30 + 8'(k);
      sendFrame(8'h30 + 8'(k), 1'b0, 1'b0);
    end
    check("R3 full after overflow", rxFull, 1);
    for (int k = 0; k < 4; k++) popCheck("R3 overflow keeps first four", 8'h30 + 8'(k));
    check("R3 empty after overflow drain", rxEmpty, 1);

    // R2 R10 R8: parity error handling
    parityOff = 1'b0; parityOdd = 1'b1;
    sendFrame(8'hA5, 1'b1, 1'b0);
    check("R2 parity error set", parityErr, 1);
    check("R6 no frame error on parity fault", frameErr, 0);
    check("R2 bad-parity char stored", rdData, 8'hA5);
    drain();
    ieErr = 1'b0;
    @(negedge clk);
    check("R10 error irq masked", irq, 0);
    ieErr = 1'b1;
    @(negedge clk);
    check("R10 error irq enabled", irq, 1);
    errClr = 3'b010;
    @(negedge clk);
    errClr = 3'b000;
    check("R8 clearing frame bit keeps parity", parityErr, 1);
    errClr = 3'b001;
    @(negedge clk);
    errClr = 3'b000;
    check("R8 parity cleared", parityErr, 0);
    check("R10 irq drops after clear", irq, 0);
    ieErr = 1'b0;

    // R6: frame error on nonzero data
    parityOff = 1'b1;
    sendFrame(8'h5A, 1'b0, 1'b1);
    check("R6 frame error", frameErr, 1);
    check("R7 no break on nonzero data", breakErr, 0);
    drain();
    clearAll();

    // R7: break, then R8 independent clear
    sendFrame(8'h00, 1'b0, 1'b1);
    check("R7 break flag", breakErr, 1);
    check("R7 break also frames", frameErr, 1);
    errClr = 3'b100;
    @(negedge clk);
    errClr = 3'b000;
    check("R8 break cleared", breakErr, 0);
    check("R8 frame kept", frameErr, 1);
    drain();
    clearAll();
    sendFrame(8'h6C, 1'b0, 1'b0);
    check("R7 receives again after break", rdData, 8'h6C);
    drain();

    // R11: short glitch ignored
    rxLine = 1'b0;
    repeat (4) @(negedge clk);
    rxLine = 1'b1;
    repeat (200) @(negedge clk);
    check("R11 glitch ignored", rxEmpty, 1);

    // R10: data-ready interrupt
    trigLevel = 2'd0; ieRda = 1'b1;
    sendFrame(8'h11, 1'b0, 1'b0);
    check("R10 data-ready irq", irq, 1);
    ieRda = 1'b0;
    @(negedge clk);
    check("R10 data-ready irq masked", irq, 0);
    drain();

    // R9: timeout window
    toCount = 8'd3; ieTo = 1'b1;
    sendFrame(8'h22, 1'b0, 1'b0);
    repeat (17) @(negedge clk);
    check("R9 no timeout too early", toFlag, 0);
    repeat (40) @(negedge clk);
    check("R9 timeout fired", toFlag, 1);
    check("R10 timeout irq", irq, 1);
    toClr = 1'b1;
    @(negedge clk);
    toClr = 1'b0;
    check("R9 timeout cleared", toFlag, 0);
    drain();
    toCount = 8'd0;
    sendFrame(8'h33, 1'b0, 1'b0);
    repeat (300) @(negedge clk);
    check("R9 zero count disables timeout", toFlag, 0);
    drain();
    repeat (300) @(negedge clk);
    toCount = 8'd2;
    repeat (100) @(negedge clk);
    check("R9 no timeout with empty queue", toFlag, 0);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
    $finish;
  end
endmodule